// File: doc/BRIEF.md
# Hue to RGBW Channel Converter

This block turns one colour request into the four brightness words of an RGBW lamp. A request is a hue, a white level and a lamp number. The hue walks around the colour wheel in six equal sectors. Within each sector, every colour channel is held at full scale, held at zero, or ramped linearly up or down. The white level is copied through unchanged as a fourth channel.

A request is accepted on any clock in which `in_valid` is high. The result is registered one clock later, and `out_valid` marks that cycle. The four words come out on one packed bus in a fixed slot order. A channel base index equal to four times the lamp number comes with them, so a downstream buffer can store the words at consecutive channel positions.

Top module: `hrgbw_conv`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `out_valid`, `out_chan` and `out_base` all at zero, even if `in_valid` is high.
- R2: When `in_valid` is high at a rising edge, the matching result and `out_valid`=1 appear after that edge. When `in_valid` is low at a rising edge, `out_valid` is 0 after it.
- R3: When `in_valid` is low at a rising edge, `out_chan` and `out_base` keep their previous values.
- R4: The hue is split into two fields. The sector is `in_hue[14:12]` and the ramp position j is `in_hue[11:0]`. Full scale F is 4095.
- R5: Sectors 0 to 2 produce these colours:
  - sector 0: red=F, green=0, blue=j
  - sector 1: red=F−j, green=0, blue=F
  - sector 2: red=0, green=j, blue=F
- R6: Sectors 3 to 5 produce these colours:
  - sector 3: red=0, green=F, blue=F−j
  - sector 4: red=j, green=F, blue=0
  - sector 5: red=F, green=F−j, blue=0
- R7: A sector value of 6 or 7 drives red, green and blue to 0.
- R8: The white slot carries `in_white` unchanged in every sector, including 6 and 7.
- R9: The bus `out_chan` holds slot k in bits [12k+11:12k]. Slot 0 is white, slot 1 is red, slot 2 is green and slot 3 is blue. `out_base` equals 4 × `in_lamp`.
- R10: For any sector from 0 to 5, at least one colour is at F and at least one colour is at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_hue | input | 15 | Hue: sector in the top 3 bits, ramp position in the low 12 bits |
| in_white | input | 12 | White level |
| in_lamp | input | 3 | Lamp number |
| out_valid | output | 1 | Result registered in this cycle |
| out_chan | output | 48 | Packed words: white, red, green, blue, from the low slot up |
| out_base | output | 5 | First channel position of the lamp (4 × lamp) |

## Verification
The assertions assume that `in_valid`, `in_hue`, `in_white` and `in_lamp` are settled before each rising edge and hold a known value whenever `in_valid` is high. They make no assumption about the hue range: sectors 6 and 7 are legal input with a defined result. The stimulus changes every input on the falling edge only. Random hues are drawn across all eight sector codes so that out-of-range values also occur, and requests are mixed with idle cycles. Directed cases place j at 0, 1, a middle value and 4095 in every sector.

// File: rtl/hrgbw_pkg.sv
package hrgbw_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'd0,
    LVL_FULL = 2'd1,
    LVL_RISE = 2'd2,
    LVL_FALL = 2'd3
  } lvl_mode_e;

  localparam int COL_RED   = 0;
  localparam int COL_GREEN = 1;
  localparam int COL_BLUE  = 2;
  localparam int NUM_COL   = 3;

  // sector-to-level table for one colour; codes 6 and 7 give zero
  function automatic lvl_mode_e mode_for(input int col, input logic [2:0] sec);
    lvl_mode_e m;
    m = LVL_ZERO;
    case (col)
      COL_RED: begin
        case (sec)
          3'd0, 3'd5: m = LVL_FULL;
          3'd1:       m = LVL_FALL;
          3'd4:       m = LVL_RISE;
          default:    m = LVL_ZERO;
        endcase
      end
      COL_GREEN: begin
        case (sec)
          3'd3, 3'd4: m = LVL_FULL;
          3'd2:       m = LVL_RISE;
          3'd5:       m = LVL_FALL;
          default:    m = LVL_ZERO;
        endcase
      end
      default: begin
        case (sec)
          3'd1, 3'd2: m = LVL_FULL;
          3'd0:       m = LVL_RISE;
          3'd3:       m = LVL_FALL;
          default:    m = LVL_ZERO;
        endcase
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/hrgbw_split.sv
module hrgbw_split #(
  parameter int BITS = 12,
  parameter int SEC_W = 3,
  localparam int HUE_W = BITS + SEC_W
) (
  input  logic [HUE_W-1:0] hue,
  output logic [SEC_W-1:0] sector,
  output logic [BITS-1:0]  pos
);
  assign sector = hue[HUE_W-1:BITS];
  assign pos    = hue[BITS-1:0];
endmodule

// File: rtl/hrgbw_ramp.sv
module hrgbw_ramp
  import hrgbw_pkg::*;
#(
  parameter int BITS = 12
) (
  input  lvl_mode_e       mode,
  input  logic [BITS-1:0] pos,
  output logic [BITS-1:0] level
);
  localparam logic [BITS-1:0] FULL = {BITS{1'b1}};

  always_comb begin
    case (mode)
      LVL_FULL: level = FULL;
      LVL_RISE: level = pos;
      LVL_FALL: level = FULL - pos;
      default:  level = '0;
    endcase
  end
endmodule

// File: rtl/hrgbw_outreg.sv
module hrgbw_outreg #(
  parameter int DATA_W = 48,
  parameter int BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_data,
  input  logic [BASE_W-1:0] d_base,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic [BASE_W-1:0] q_base
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_base  <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_data <= d_data;
        q_base <= d_base;
      end
    end
  end
endmodule

// File: rtl/hrgbw_conv.sv
module hrgbw_conv
  import hrgbw_pkg::*;
#(
  parameter int BITS   = 12,
  parameter int LAMP_W = 3,
  localparam int SEC_W  = 3,
  localparam int HUE_W  = BITS + SEC_W,
  localparam int SLOTS  = 4,
  localparam int DATA_W = SLOTS * BITS,
  localparam int BASE_W = LAMP_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [HUE_W-1:0]  in_hue,
  input  logic [BITS-1:0]   in_white,
  input  logic [LAMP_W-1:0] in_lamp,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_chan,
  output logic [BASE_W-1:0] out_base
);
  logic [SEC_W-1:0] sector;
  logic [BITS-1:0]  pos;
  logic [BITS-1:0]  col_lvl [NUM_COL];
  logic [DATA_W-1:0] packed_next;
  logic [BASE_W-1:0] base_next;

  hrgbw_split #(.BITS(BITS), .SEC_W(SEC_W)) u_split (
    .hue(in_hue), .sector(sector), .pos(pos)
  );

  for (genvar c = 0; c < NUM_COL; c++) begin : g_col
    lvl_mode_e mode;
    assign mode = mode_for(c, sector);
    hrgbw_ramp #(.BITS(BITS)) u_ramp (
      .mode(mode), .pos(pos), .level(col_lvl[c])
    );
    // slot 0 is white, colours follow in slots 1..3
    assign packed_next[BITS*(c+1) +: BITS] = col_lvl[c];
  end

  assign packed_next[BITS-1:0] = in_white;
  assign base_next = {in_lamp, 2'b00};

  hrgbw_outreg #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_reg (
    .clk(clk), .rst(rst), .load(in_valid),
    .d_data(packed_next), .d_base(base_next),
    .q_valid(out_valid), .q_data(out_chan), .q_base(out_base)
  );
endmodule

// File: rtl/hrgbw_chk.sv
module hrgbw_chk #(
  parameter int BITS   = 12,
  parameter int LAMP_W = 3,
  localparam int HUE_W  = BITS + 3,
  localparam int DATA_W = 4 * BITS,
  localparam int BASE_W = LAMP_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [HUE_W-1:0]  in_hue,
  input logic [BITS-1:0]   in_white,
  input logic [LAMP_W-1:0] in_lamp,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_chan,
  input logic [BASE_W-1:0] out_base
);
  localparam logic [BITS-1:0] FULL = {BITS{1'b1}};
  logic [BITS-1:0] r_o, g_o, b_o;
  assign r_o = out_chan[BITS +: BITS];
  assign g_o = out_chan[2*BITS +: BITS];
  assign b_o = out_chan[3*BITS +: BITS];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_chan == '0 && out_base == '0));
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_chan) && $stable(out_base)));
  // R8
  white_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_chan[BITS-1:0] == $past(in_white));
  // R9
  base_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_base == {$past(in_lamp), 2'b00});
  // R7
  off_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_hue[HUE_W-1:BITS] >= 3'd6) |=> (r_o == '0 && g_o == '0 && b_o == '0));
  // R10
  extreme_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_hue[HUE_W-1:BITS] < 3'd6) |=>
      ((r_o == FULL || g_o == FULL || b_o == FULL) &&
       (r_o == '0 || g_o == '0 || b_o == '0)));
endmodule

bind hrgbw_conv hrgbw_chk #(.BITS(BITS), .LAMP_W(LAMP_W)) u_chk (.*);

// File: tb/test_hrgbw_conv.sv
module test_hrgbw_conv;
  localparam int BITS = 12;
  localparam int F = 4095;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [14:0] in_hue = '0;
  logic [11:0] in_white = '0;
  logic [2:0]  in_lamp = '0;
  logic        out_valid;
  logic [47:0] out_chan;
  logic [4:0]  out_base;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [47:0] exp_chan = '0;
  logic [4:0]  exp_base = '0;

  always #2.5 clk = ~clk;

  hrgbw_conv i_hrgbw_conv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hue(in_hue),
    .in_white(in_white), .in_lamp(in_lamp), .out_valid(out_valid),
    .out_chan(out_chan), .out_base(out_base)
  );

  function automatic logic [47:0] model(input logic [14:0] h, input logic [11:0] w);
    int s, j, r, g, b;
    s = int'(h[14:12]);
    j = int'(h[11:0]);
    r = 0; g = 0; b = 0;
    case (s)
      0: begin r = F;     g = 0;     b = j;     end
      1: begin r = F - j; g = 0;     b = F;     end
      2: begin r = 0;     g = j;     b = F;     end
      3: begin r = 0;     g = F;     b = F - j; end
      4: begin r = j;     g = F;     b = 0;     end
      5: begin r = F;     g = F - j; b = 0;     end
      default: begin r = 0; g = 0; b = 0; end
    endcase
    return {b[11:0], g[11:0], r[11:0], w};
  endfunction

  function automatic string tag_for(input logic [14:0] h);
    if (h[14:12] >= 3'd6) return "R7";
    if (h[14:12] >= 3'd3) return "R6";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, check at the next falling edge
  task automatic step(input bit v, input logic [14:0] h, input logic [11:0] w,
                      input logic [2:0] l);
    in_valid = v; in_hue = h; in_white = w; in_lamp = l;
    if (v) begin
      exp_chan = model(h, w);
      exp_base = {l, 2'b00};
    end
    @(negedge clk);
    check(v ? "R2" : "R2/R3 idle", {63'd0, out_valid}, {63'd0, v});
    check(v ? {tag_for(h), "/R9"} : "R3", {16'd0, out_chan}, {16'd0, exp_chan});
    check(v ? "R8" : "R3", {52'd0, out_chan[11:0]}, {52'd0, exp_chan[11:0]});
    check("R9 base", {59'd0, out_base}, {59'd0, exp_base});
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {63'd0, out_valid}, 64'd0);
    check("R1 chan", {16'd0, out_chan}, 64'd0);
    check("R1 base", {59'd0, out_base}, 64'd0);
    rst = 1'b0;

    // R4 R5 R6 R10: every sector at ramp ends and middle
    for (int s = 0; s < 8; s++) begin
      step(1, {s[2:0], 12'd0},    12'd819, s[2:0]);
      step(1, {s[2:0], 12'd1},    12'd0,   3'd7);
      step(1, {s[2:0], 12'd2048}, 12'hABC, 3'd2);
      step(1, {s[2:0], 12'hFFF},  12'hFFF, 3'd5);
    end
    // R4 explicit field split: sector 4, j=0x123 -> red=0x123, green=F, blue=0
    step(1, 15'h4123, 12'h055, 3'd1);
    check("R4 red", {52'd0, out_chan[23:12]}, 64'h123);
    check("R4 green", {52'd0, out_chan[35:24]}, 64'hFFF);
    // R3 hold over idle cycles with changing inputs
    step(0, 15'h7FFF, 12'h111, 3'd6);
    step(0, 15'h0000, 12'h222, 3'd3);

    // random mix
    for (int n = 0; n < 600; n++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, 15'($urandom % 32768), 12'($urandom), 3'($urandom));
    end

    // R1 reset wins over a valid request
    step(1, 15'h1234, 12'h0F0, 3'd3);
    rst = 1'b1; in_valid = 1'b1; in_hue = 15'h2345; in_white = 12'h777; in_lamp = 3'd6;
    @(negedge clk);
    check("R1 mid valid", {63'd0, out_valid}, 64'd0);
    check("R1 mid chan", {16'd0, out_chan}, 64'd0);
    check("R1 mid base", {59'd0, out_base}, 64'd0);
    rst = 1'b0; exp_chan = '0; exp_base = '0;
    step(0, 15'd0, 12'd0, 3'd0);
    step(1, 15'h5FFF, 12'h001, 3'd4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule